// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Per-Byte Packet Tags

This block sits between an HDLC deframer and a host. The deframer hands it one byte at a time, marks the byte that precedes a closing flag, reports the FCS verdict with that byte, and signals a frame abort on a separate pulse. The block stores each byte together with a 2-bit tag that tells the host where the byte sits in its packet. Bytes leave in arrival order through a read port that shows the oldest byte and its tag.

Four sticky flags tell the host when to act:
- the queue is close to full;
- a packet has ended;
- a frame was aborted;
- a byte was lost because the queue was full.

An abort closes the open packet by retagging its newest stored byte as a bad-FCS end. The host therefore handles an aborted frame on the same path as any other failed packet. A status-read strobe clears the flags.

Top module: `rxq_stat_fifo`

## Requirements
- R1: After reset the queue is empty (`fill` = 0, `rd_valid` = 0) and all four flags and `irq` are 0.
- R2: The queue holds 19 entries. Bytes are read out in the order they were accepted, with their data unchanged. `fill` equals the number of stored entries.
- R3: Tag encoding for a byte that is not a packet end: 2'b01 for the first byte of a packet (the first byte after reset, after a packet end or after an abort), and 2'b00 for any later byte.
- R4: A byte presented with `in_last`=1 is stored with tag 2'b10 when `in_fcs_bad`=0 and 2'b11 when `in_fcs_bad`=1. This applies to a one-byte packet too.
- R5: A byte presented with `in_last`=1 sets `flag_eop`.
- R6: `flag_thresh` is set in every cycle in which the occupancy reaches or stays at 15 or more.
- R7: A byte presented while 19 entries are stored is discarded. It sets `flag_ovf` and leaves the stored entries and `fill` unchanged.
- R8: An `in_abort` pulse sets `flag_eop` and `flag_abort`. Any byte presented in the same cycle is ignored. The newest stored byte of the still-open packet is retagged 2'b11.
- R9: An abort retags nothing when no byte of an open packet is stored, for example right after a packet end.
- R10: Flags stay set until a cycle with `istat_rd`=1 clears them. An event in that same cycle leaves its own flag set.
- R11: `irq` is 1 exactly when at least one flag is set.
- R12: `rd_en` while the queue is empty changes neither `fill` nor the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Deframer byte strobe |
| in_data | input | 8 | Deframer byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_fcs_bad | input | 1 | FCS failed (qualified by in_last) |
| in_abort | input | 1 | Frame abort pulse |
| rd_en | input | 1 | Host pops the oldest entry |
| rd_data | output | 8 | Oldest stored byte |
| rd_tag | output | 2 | Tag of the oldest stored byte |
| rd_valid | output | 1 | Queue not empty |
| fill | output | 5 | Number of stored entries |
| istat_rd | input | 1 | Host status read; clears flags |
| flag_thresh | output | 1 | Occupancy reached 15 |
| flag_eop | output | 1 | Packet end seen |
| flag_abort | output | 1 | Frame abort seen |
| flag_ovf | output | 1 | Byte dropped on full queue |
| irq | output | 1 | Any flag set |

## Verification
The bench fills the queue past the threshold and then to full, and offers two more bytes. A design that wraps or overwrites would return corrupt data, or report 21 bytes where only 19 are stored.

Aborts are driven in two situations: with a packet open and a byte offered in the same cycle, and right after a packet has closed. A design that retags blindly would mark a finished packet bad. One that accepts the abort-cycle byte would grow `fill`.

The bench also clears the status flags in the same cycle as a new abort. A design that lets the clear win would lose the event.

Further cases are one-byte packets with each FCS verdict and reads of an empty queue. These catch tag-priority mistakes and spurious pointer motion.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TAG_MID     = 2'b00,
        TAG_HEAD    = 2'b01,
        TAG_END_OK  = 2'b10,
        TAG_END_BAD = 2'b11
    } rxq_tag_e;

    typedef struct packed {
        logic thresh;
        logic eop;
        logic abort;
        logic ovf;
    } rxq_flags_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int THRESH = 15,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_fcs_bad,
    input  logic             in_abort,
    input  logic             rd_en,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output rxq_tag_e         wr_tag,
    output logic             fix_en,
    output logic [IDX_W-1:0] fix_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] fill,
    output rxq_flags_t       events
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] THR_CNT  = CNT_W'(THRESH);

    typedef struct packed {
        logic [IDX_W-1:0] wr_ptr;
        logic [IDX_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        logic             open;
        logic             tail_open;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic             pop, full, take, drop;
    logic [CNT_W-1:0] left;

    function automatic logic [IDX_W-1:0] step_up(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] step_dn(input logic [IDX_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        pop  = rd_en && (st_q.count != '0);
        full = (st_q.count == FULL_CNT);
        take = in_valid && !in_abort && !full;
        drop = in_valid && !in_abort && full;
        left = st_q.count - CNT_W'(pop);

        if (in_last)
            wr_tag = in_fcs_bad ? TAG_END_BAD : TAG_END_OK;
        else
            wr_tag = st_q.open ? TAG_MID : TAG_HEAD;

        if (take) st_d.wr_ptr = step_up(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = step_up(st_q.rd_ptr);
        st_d.count = st_q.count + CNT_W'(take) - CNT_W'(pop);

        if (in_abort)
            st_d.open = 1'b0;
        else if (in_valid)
            st_d.open = !in_last;

        if (in_abort)
            st_d.tail_open = 1'b0;
        else if (in_valid && in_last)
            st_d.tail_open = 1'b0;
        else if (take)
            st_d.tail_open = 1'b1;

        fix_en  = in_abort && st_q.tail_open && (left != '0);
        fix_idx = step_dn(st_q.wr_ptr);

        events.thresh = (st_d.count >= THR_CNT);
        events.eop    = in_abort || (in_valid && in_last);
        events.abort  = in_abort;
        events.ovf    = drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en  = take;
    assign wr_idx = st_q.wr_ptr;
    assign rd_idx = st_q.rd_ptr;
    assign fill   = st_q.count;

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  rxq_tag_e          wr_tag,
    input  logic              fix_en,
    input  logic [IDX_W-1:0]  fix_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_tag
);

    localparam int ENT_W = DATA_W + 2;

    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en)
            mem_d[wr_idx] = {wr_tag, wr_data};
        if (fix_en)
            mem_d[fix_idx][ENT_W-1:DATA_W] = TAG_END_BAD;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_idx][DATA_W-1:0];
    assign rd_tag  = mem_q[rd_idx][ENT_W-1:DATA_W];

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       istat_rd,
    input  rxq_flags_t events,
    output rxq_flags_t flags
);

    rxq_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = istat_rd ? '0 : flags_q;
        flags_d = flags_d | events;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/rxq_stat_fifo.sv
module rxq_stat_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int THRESH = 15,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_fcs_bad,
    input  logic              in_abort,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_tag,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  fill,
    input  logic              istat_rd,
    output logic              flag_thresh,
    output logic              flag_eop,
    output logic              flag_abort,
    output logic              flag_ovf,
    output logic              irq
);

    logic             wr_en, fix_en;
    logic [IDX_W-1:0] wr_idx, fix_idx, rd_idx;
    rxq_tag_e         wr_tag;
    rxq_flags_t       events, flags;

    rxq_ctrl #(
        .DEPTH (DEPTH),
        .THRESH(THRESH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_fcs_bad(in_fcs_bad),
        .in_abort  (in_abort),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .fix_en    (fix_en),
        .fix_idx   (fix_idx),
        .rd_idx    (rd_idx),
        .fill      (fill),
        .events    (events)
    );

    rxq_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(in_data),
        .wr_tag (wr_tag),
        .fix_en (fix_en),
        .fix_idx(fix_idx),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .rd_tag (rd_tag)
    );

    rxq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .istat_rd(istat_rd),
        .events  (events),
        .flags   (flags)
    );

    assign rd_valid    = (fill != '0);
    assign flag_thresh = flags.thresh;
    assign flag_eop    = flags.eop;
    assign flag_abort  = flags.abort;
    assign flag_ovf    = flags.ovf;
    assign irq         = |flags;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH  = 19,
    parameter int THRESH = 15,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_abort,
    input logic             rd_en,
    input logic             istat_rd,
    input logic             rd_valid,
    input logic [CNT_W-1:0] fill,
    input logic             flag_thresh,
    input logic             flag_eop,
    input logic             flag_abort,
    input logic             flag_ovf
);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_abort && fill == CNT_W'(DEPTH)) |=>
        (flag_ovf && (fill == ($past(rd_en) ? CNT_W'(DEPTH - 1) : CNT_W'(DEPTH)))));

    // R8
    abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_abort |=> (flag_eop && flag_abort));

    // R8
    abort_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_abort && !rd_en) |=> (fill == $past(fill)));

    // R6
    thresh_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill >= CNT_W'(THRESH)) |-> flag_thresh);

    // R10
    eop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_eop && !istat_rd) |=> flag_eop);

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (istat_rd && !in_abort) |=> !flag_abort);

    // R12
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_valid && !in_valid) |=> (fill == '0));

endmodule

bind rxq_stat_fifo rxq_chk #(
    .DEPTH (DEPTH),
    .THRESH(THRESH),
    .CNT_W (CNT_W)
) u_rxq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_abort   (in_abort),
    .rd_en      (rd_en),
    .istat_rd   (istat_rd),
    .rd_valid   (rd_valid),
    .fill       (fill),
    .flag_thresh(flag_thresh),
    .flag_eop   (flag_eop),
    .flag_abort (flag_abort),
    .flag_ovf   (flag_ovf)
);

// File: tb/rxq_stat_fifo_bench.sv
`timescale 1ns/1ps
module rxq_stat_fifo_bench;

    localparam int DEPTH = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0, in_fcs_bad = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = '0;
    logic       rd_en = 1'b0, istat_rd = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;
    logic       rd_valid, flag_thresh, flag_eop, flag_abort, flag_ovf, irq;
    logic [4:0] fill;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct { logic [7:0] d; logic [1:0] t; } item_t;
    item_t q[$];
    bit m_open = 0;
    bit m_tail_open = 0;

    always #4 clk = ~clk;

    rxq_stat_fifo u_rxq_stat_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_fcs_bad(in_fcs_bad), .in_abort(in_abort),
        .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .fill(fill), .istat_rd(istat_rd), .flag_thresh(flag_thresh),
        .flag_eop(flag_eop), .flag_abort(flag_abort), .flag_ovf(flag_ovf), .irq(irq)
    );

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one byte, model tracks tag, capacity and packet state
    task automatic put(input logic [7:0] d, input bit last, input bit fbad);
        item_t it;
        in_valid = 1; in_data = d; in_last = last; in_fcs_bad = fbad;
        it.d = d;
        it.t = last ? (fbad ? 2'b11 : 2'b10) : (m_open ? 2'b00 : 2'b01);
        if (q.size() < DEPTH) begin
            q.push_back(it);
            m_tail_open = !last;
        end else if (last) begin
            m_tail_open = 0;
        end
        m_open = !last;
        @(negedge clk);
        in_valid = 0; in_last = 0; in_fcs_bad = 0;
    endtask

    task automatic abort_pkt(input bit with_byte, input bit with_stat);
        in_abort = 1; in_valid = with_byte; in_data = 8'h99; istat_rd = with_stat;
        if (m_tail_open && q.size() > 0) q[q.size()-1].t = 2'b11;
        m_open = 0; m_tail_open = 0;
        @(negedge clk);
        in_abort = 0; in_valid = 0; istat_rd = 0;
    endtask

    task automatic rd(input int n);
        rd_en = 1;
        repeat (n) @(negedge clk);
        rd_en = 0;
    endtask

    task automatic stat_rd();
        istat_rd = 1;
        @(negedge clk);
        istat_rd = 0;
    endtask

    // monitor: compares each popped entry with the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && rd_en && rd_valid) begin
                if (q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R2 actual=%0h expected=empty", rd_data);
                end else begin
                    item_t e;
                    e = q.pop_front();
                    check(rd_data, e.d, "R2 data order");
                    check(rd_tag, e.t, "R3 R4 tag");
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(fill, 0, "R1 fill");
        check(rd_valid, 0, "R1 valid");
        check({flag_thresh, flag_eop, flag_abort, flag_ovf}, 0, "R1 flags");
        check(irq, 0, "R1 irq");
        @(negedge clk);

        // normal four-byte packet
        put(8'hA0, 0, 0); put(8'hA1, 0, 0); put(8'hA2, 0, 0); put(8'hA3, 1, 0);
        check(fill, 4, "R2 fill");
        check(flag_eop, 1, "R5 eop");
        check(flag_thresh, 0, "R6 below");
        check(irq, 1, "R11 irq");
        rd(4);
        check(fill, 0, "R2 drained");
        check(flag_eop, 1, "R10 sticky");
        stat_rd();
        check({flag_thresh, flag_eop, flag_abort, flag_ovf}, 0, "R10 clear");
        check(irq, 0, "R11 idle");

        // one-byte packets, bad then good
        put(8'h5A, 1, 1); put(8'h33, 1, 0);
        rd(2);
        stat_rd();

        // threshold and overflow
        for (int i = 0; i < 14; i++) put(8'(8'h40 + i), 0, 0);
        check(flag_thresh, 0, "R6 at 14");
        put(8'h4E, 0, 0);
        check(flag_thresh, 1, "R6 at 15");
        for (int i = 0; i < 4; i++) put(8'(8'h50 + i), 0, 0);
        check(fill, 19, "R7 full");
        check(flag_ovf, 0, "R7 no ovf yet");
        put(8'hEE, 0, 0); put(8'hEF, 0, 0);
        check(fill, 19, "R7 fill kept");
        check(flag_ovf, 1, "R7 ovf");
        rd(19);
        stat_rd();
        check({flag_thresh, flag_eop, flag_abort, flag_ovf}, 0, "R10 clear after drain");
        put(8'h77, 1, 0);
        rd(1);
        stat_rd();

        // abort on open packet, byte offered in same cycle
        put(8'h10, 0, 0); put(8'h11, 0, 0); put(8'h12, 0, 0);
        abort_pkt(1, 0);
        check(fill, 3, "R8 byte ignored");
        check(flag_eop, 1, "R8 eop");
        check(flag_abort, 1, "R8 abort");
        rd(3);
        stat_rd();

        // abort with no open packet stored
        put(8'h21, 0, 0); put(8'h22, 1, 0);
        abort_pkt(0, 0);
        check(fill, 2, "R9 fill");
        check(flag_abort, 1, "R9 flag");
        rd(2);
        stat_rd();

        // clear and new abort in the same cycle
        abort_pkt(0, 0);
        abort_pkt(0, 1);
        check(flag_abort, 1, "R10 event wins");
        check(flag_eop, 1, "R10 eop wins");
        stat_rd();
        check(flag_abort, 0, "R10 cleared");

        // reads of an empty queue
        rd(2);
        check(fill, 0, "R12 fill");
        check(rd_valid, 0, "R12 valid");
        put(8'h44, 1, 0);
        check(rd_data, 8'h44, "R12 head");
        check(rd_tag, 2'b10, "R4 single good");
        rd(1);
        check(fill, 0, "R2 final");
        check(q.size(), 0, "R2 scoreboard empty");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule